// File: doc/BRIEF.md
# DMA Source Address Sequencer

This block produces the read address for every source-side access of one DMA channel. It keeps a current source address register and shows it to a bus master together with the width of the access. When the master signals that the access has finished, the register moves on to the next address to be read. Software-side logic loads a starting address through a strobe. A mode field selects how the address moves from one datum to the next: it can stay fixed, add a signed offset, step up by the datum size or step down by the datum size.

Data can be bytes, 16-bit words or 32-bit longwords. A word or longword that starts on an address not aligned to its own width cannot be read in one access. The sequencer splits it into aligned byte and word sub-accesses and walks upward through the datum. Once the last piece is acknowledged, the next datum address is computed from the address where the datum started, and a one-cycle datum-complete pulse is raised. All arithmetic wraps at the address width.

Top module: `dsa_src_seq`

## Requirements
- R1: While reset is high and after it is released, the address output is zero and no split is in progress, so `rd_size` equals `cfg_size` (byte for code 00).
- R2: A cycle with `ld_en` high places `ld_addr` on `rd_addr` from the next cycle on. It abandons any partly done split, and `datum_done` stays low in that cycle even when `acc_done` is also high.
- R3: `cfg_size` coding: 00 byte (step 1), 01 word (step 2), 10 longword (step 4), 11 behaves as byte. `rd_size` uses the same coding, 00/01/10, and never shows 11.
- R4: With `cfg_mode` = 10, each completed datum moves the start address up by the datum step.
- R5: With `cfg_mode` = 11, each completed datum moves the start address down by the datum step.
- R6: With `cfg_mode` = 00, the address stays put and returns to the datum start after a split datum.
- R7: With `cfg_mode` = 01, the next start is the start plus `cfg_offset` modulo 2^ADDR_W. A negative step is given as its two's complement (offset 0xFFFE0001 moves 0x00020000 to 0x00000001).
- R8: A word at an odd address is read as a byte at A and then a byte at A+1.
- R9: A longword at an address with low bits 10 is read as a word at A and then a word at A+2.
- R10: A longword at an address with low bits 01 or 11 is read as a byte at A, a word at A+1 and a byte at A+3. Every word access is even and every longword access is 4-aligned.
- R11: After a split datum, the next start address is the datum start address updated by the mode, not the last sub-access address.
- R12: `datum_done` is high exactly in the cycles where `acc_done` acknowledges the final sub-access of a datum.
- R13: Address arithmetic wraps modulo 2^ADDR_W in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Address update rule: 00 fixed, 01 offset, 10 up, 11 down |
| cfg_size | input | 2 | Datum size: 00 byte, 01 word, 10 longword, 11 byte |
| cfg_offset | input | ADDR_W | Two's-complement offset for mode 01 |
| ld_en | input | 1 | Load strobe for the start address |
| ld_addr | input | ADDR_W | Address written on `ld_en` |
| acc_done | input | 1 | Bus master acknowledges the current access |
| rd_addr | output | ADDR_W | Address of the current access |
| rd_size | output | 2 | Width of the current access: 00 byte, 01 word, 10 longword |
| datum_done | output | 1 | Final sub-access of a datum acknowledged |

## Verification
The bench builds the block with the default ADDR_W of 32. This makes the full-width offset example reachable, and it lets loads near 0xFFFFFFFF and near zero reach the wrap at 2^32 in both directions. A reference model in the bench expands each datum into its expected sub-accesses for every alignment of the start address: aligned, odd, and low bits 10, 01 and 11. A scoreboard compares each acknowledged access against those expected sub-accesses. Separate directed steps cover aborting a split with a load and a load that arrives together with an acknowledge.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_OFFS = 2'b01,
    MODE_UP   = 2'b10,
    MODE_DOWN = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } asize_e;

  // bytes moved by one access of the given size code (reserved -> 1)
  function automatic logic [2:0] size_bytes(input logic [1:0] s);
    case (s)
      SZ_WORD: size_bytes = 3'd2;
      SZ_LONG: size_bytes = 3'd4;
      default: size_bytes = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/dsa_split_plan.sv
// Decides the width of sub-access number idx of a datum whose start address
// has the given low bits, and whether that sub-access is the final one.
module dsa_split_plan
  import dsa_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic [1:0]       size,
  input  logic [1:0]       lo,
  input  logic [IDX_W-1:0] idx,
  output logic [1:0]       sub_size,
  output logic [2:0]       sub_bytes,
  output logic             last
);

  always_comb begin
    sub_size = SZ_BYTE;
    last     = 1'b1;
    case (size)
      SZ_WORD: begin
        if (lo[0]) begin
          sub_size = SZ_BYTE;
          last     = (idx == IDX_W'(1));
        end else begin
          sub_size = SZ_WORD;
        end
      end
      SZ_LONG: begin
        case (lo)
          2'b00: sub_size = SZ_LONG;
          2'b10: begin
            sub_size = SZ_WORD;
            last     = (idx == IDX_W'(1));
          end
          default: begin
            sub_size = (idx == IDX_W'(1)) ? SZ_WORD : SZ_BYTE;
            last     = (idx == IDX_W'(2));
          end
        endcase
      end
      default: begin
        sub_size = SZ_BYTE;
        last     = 1'b1;
      end
    endcase
  end

  assign sub_bytes = size_bytes(sub_size);

endmodule

// File: rtl/dsa_next_addr.sv
// Next datum start address, derived from the current datum start address.
module dsa_next_addr
  import dsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] start,
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] next
);

  localparam int PAD_W = ADDR_W - 3;

  logic [ADDR_W-1:0] step;
  assign step = {{PAD_W{1'b0}}, size_bytes(size)};

  always_comb begin
    case (mode)
      MODE_OFFS: next = start + offset;
      MODE_UP:   next = start + step;
      MODE_DOWN: next = start - step;
      default:   next = start;
    endcase
  end

endmodule

// File: rtl/dsa_src_seq.sv
module dsa_src_seq
  import dsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_size,
  input  logic [ADDR_W-1:0] cfg_offset,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              acc_done,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_size,
  output logic              datum_done
);

  localparam int IDX_W = 2;   // up to three sub-accesses per datum
  localparam int PAD_W = ADDR_W - 3;

  logic [ADDR_W-1:0] cur_q, start_q, nxt;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        sub_size;
  logic [2:0]        sub_bytes;
  logic              last;

  dsa_split_plan #(.IDX_W(IDX_W)) u_plan (
    .size     (cfg_size),
    .lo       (start_q[1:0]),
    .idx      (idx_q),
    .sub_size (sub_size),
    .sub_bytes(sub_bytes),
    .last     (last)
  );

  dsa_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .start (start_q),
    .mode  (cfg_mode),
    .size  (cfg_size),
    .offset(cfg_offset),
    .next  (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      start_q <= '0;
      idx_q   <= '0;
    end else if (ld_en) begin
      cur_q   <= ld_addr;
      start_q <= ld_addr;
      idx_q   <= '0;
    end else if (acc_done) begin
      if (last) begin
        cur_q   <= nxt;
        start_q <= nxt;
        idx_q   <= '0;
      end else begin
        cur_q   <= cur_q + {{PAD_W{1'b0}}, sub_bytes};
        idx_q   <= idx_q + IDX_W'(1);
      end
    end
  end

  assign rd_addr    = cur_q;
  assign rd_size    = sub_size;
  assign datum_done = acc_done & last & ~ld_en;

  // R2: a load takes effect on the next cycle and restarts the datum
  a_r2_load_takes: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (rd_addr == $past(ld_addr) && idx_q == '0));

  // R12: completion only reported on an acknowledge
  a_r12_done_needs_ack: assert property (@(posedge clk) disable iff (rst)
    datum_done |-> acc_done);

  // R3: reserved code never reaches the bus
  a_r3_size_legal: assert property (@(posedge clk) disable iff (rst)
    rd_size != SZ_RSVD);

  // R10: every word and longword access is naturally aligned
  a_r10_word_even: assert property (@(posedge clk) disable iff (rst)
    (rd_size == SZ_WORD) |-> (rd_addr[0] == 1'b0));
  a_r10_long_align: assert property (@(posedge clk) disable iff (rst)
    (rd_size == SZ_LONG) |-> (rd_addr[1:0] == 2'b00));

  // R8: inside a datum the address advances by the width just read
  a_r8_sub_advance: assert property (@(posedge clk) disable iff (rst)
    (acc_done && !ld_en && !datum_done) |=>
      (rd_addr == $past(rd_addr) + {{PAD_W{1'b0}}, size_bytes($past(rd_size))}));

  // R10: at most three sub-accesses per datum
  a_r10_idx_bound: assert property (@(posedge clk) disable iff (rst)
    idx_q <= IDX_W'(2));

endmodule

// File: tb/dsa_src_seq_tb.sv
module dsa_src_seq_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cfg_mode = 2'b10;
  logic [1:0]    cfg_size = 2'b00;
  logic [AW-1:0] cfg_offset = '0;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic          acc_done = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [1:0]    rd_size;
  logic          datum_done;

  always #5 clk = ~clk;

  dsa_src_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_size(cfg_size),
    .cfg_offset(cfg_offset), .ld_en(ld_en), .ld_addr(ld_addr),
    .acc_done(acc_done), .rd_addr(rd_addr), .rd_size(rd_size),
    .datum_done(datum_done)
  );

  typedef struct packed {
    logic [AW-1:0] a;
    logic [1:0]    s;
    logic          l;
  } exp_t;

  exp_t          q[$];
  string         rq[$];
  int            n_chk = 0;
  int            n_fail = 0;
  bit            finished = 1'b0;
  logic [AW-1:0] m_addr = '0;

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: mid-cycle, compare each acknowledged access
  always @(negedge clk) begin
    if (!rst && acc_done && !ld_en) begin
      if (q.size() == 0) begin
        check32("R12", 32'd1, 32'd0, "unexpected access");
      end else begin
        exp_t  e;
        string r;
        e = q.pop_front();
        r = rq.pop_front();
        check32(r, rd_addr, e.a, "address");
        check32(r, {30'd0, rd_size}, {30'd0, e.s}, "size");
        check32("R12", {31'd0, datum_done}, {31'd0, e.l}, "datum_done");
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic load(logic [AW-1:0] a);
    ld_en   = 1'b1;
    ld_addr = a;
    step();
    ld_en   = 1'b0;
    m_addr  = a;
  endtask

  function automatic logic [AW-1:0] model_next(logic [AW-1:0] a);
    logic [AW-1:0] st;
    st = (cfg_size == 2'b10) ? 4 : (cfg_size == 2'b01) ? 2 : 1;
    case (cfg_mode)
      2'b01:   return a + cfg_offset;
      2'b10:   return a + st;
      2'b11:   return a - st;
      default: return a;
    endcase
  endfunction

  // driver: expand n data into expected sub-accesses, then acknowledge them
  task automatic run(int n, string rnext);
    for (int d = 0; d < n; d++) begin
      logic [AW-1:0] a;
      logic [1:0]    offs[3];
      logic [1:0]    szs[3];
      int            cnt;
      string         tag;
      a = m_addr;
      cnt = 1; offs[0] = 0; szs[0] = 2'b00; tag = "R3";
      if (cfg_size == 2'b01) begin
        if (a[0]) begin
          cnt = 2; offs[1] = 1; szs[1] = 2'b00; tag = "R8";
        end else szs[0] = 2'b01;
      end else if (cfg_size == 2'b10) begin
        if (a[1:0] == 2'b00) szs[0] = 2'b10;
        else if (a[1:0] == 2'b10) begin
          cnt = 2; szs[0] = 2'b01; offs[1] = 2; szs[1] = 2'b01; tag = "R9";
        end else begin
          cnt = 3; offs[1] = 1; szs[1] = 2'b01; offs[2] = 3; szs[2] = 2'b00; tag = "R10";
        end
      end
      for (int i = 0; i < cnt; i++) begin
        q.push_back('{a: a + AW'(offs[i]), s: szs[i], l: (i == cnt - 1)});
        rq.push_back(tag);
      end
      for (int i = 0; i < cnt; i++) begin
        acc_done = 1'b1;
        step();
      end
      acc_done = 1'b0;
      m_addr = model_next(a);
    end
    @(negedge clk);
    check32(rnext, rd_addr, m_addr, "next start address");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    step();
    step();
    @(negedge clk);
    check32("R1", rd_addr, 32'h0, "addr in reset");
    rst = 1'b0;
    step();
    @(negedge clk);
    check32("R1", rd_addr, 32'h0, "addr after reset");
    check32("R1", {30'd0, rd_size}, 32'd0, "size after reset");
    check32("R1", {31'd0, datum_done}, 32'd0, "done after reset");

    // R4 increment by byte, word, longword
    cfg_mode = 2'b10; cfg_size = 2'b00;
    load(32'h100); run(3, "R4");
    cfg_size = 2'b01; load(32'h200); run(2, "R4");
    cfg_size = 2'b10; run(2, "R4");
    // R3 reserved size behaves as byte
    cfg_size = 2'b11; load(32'h300); run(2, "R3");
    // R5 decrement longword
    cfg_mode = 2'b11; cfg_size = 2'b10; load(32'h1000); run(2, "R5");
    // R8 / R11 odd word, increment
    cfg_mode = 2'b10; cfg_size = 2'b01; load(32'h401); run(2, "R11");
    // R9 longword at ..10
    cfg_size = 2'b10; load(32'h502); run(1, "R11");
    // R10 longword at ..01 with decrement
    cfg_mode = 2'b11; load(32'h601); run(2, "R11");
    // R6 fixed mode with a split at ..11
    cfg_mode = 2'b00; load(32'h703); run(2, "R6");
    // R7 negative offset
    cfg_mode = 2'b01; cfg_size = 2'b01; cfg_offset = 32'hFFFE0001;
    load(32'h00020000); run(1, "R7");
    check32("R7", m_addr, 32'h1, "offset example");
    run(1, "R7");
    // R13 wrap upward and downward
    cfg_mode = 2'b10; cfg_size = 2'b10; load(32'hFFFFFFFE); run(1, "R13");
    check32("R13", m_addr, 32'h2, "wrap up");
    cfg_mode = 2'b11; cfg_size = 2'b00; load(32'h1); run(2, "R13");
    check32("R13", m_addr, 32'hFFFFFFFF, "wrap down");

    // R2 abort a split in progress
    cfg_mode = 2'b10; cfg_size = 2'b10; load(32'h801);
    q.push_back('{a: 32'h801, s: 2'b00, l: 1'b0}); rq.push_back("R10");
    acc_done = 1'b1; step(); acc_done = 1'b0;
    @(negedge clk);
    check32("R10", rd_addr, 32'h802, "mid-split address");
    check32("R10", {30'd0, rd_size}, 32'd1, "mid-split size");
    load(32'h900);
    @(negedge clk);
    check32("R2", rd_addr, 32'h900, "abort address");
    check32("R2", {30'd0, rd_size}, 32'd2, "abort size");
    // R2 load together with acknowledge: load wins, no completion
    ld_en = 1'b1; ld_addr = 32'hA00; acc_done = 1'b1;
    @(negedge clk);
    check32("R2", {31'd0, datum_done}, 32'd0, "done during load");
    step();
    ld_en = 1'b0; acc_done = 1'b0; m_addr = 32'hA00;
    @(negedge clk);
    check32("R2", rd_addr, 32'hA00, "load over ack");
    run(1, "R4");

    check32("R12", q.size(), 32'd0, "scoreboard drained");
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule